// File: doc/BRIEF.md
# Two-Wire Bus Slave Packet Engine

This block is the target side of a two-wire serial bus with open-drain data and clock lines. The system clock runs much faster than the bus clock. Both lines pass through a synchronizer, and the block looks for edges on the synchronized copies. It finds the framing conditions, shifts in the address packet and decides whether to answer. It then takes in write data or sends out read data, one byte per nine bus clocks. The block never drives a line high. It only requests a low level on the data line through `sda_oe`, and the pad logic turns that request into an open-drain pull-down.

On the user side, received bytes come out on a stream with a valid strobe only. There is no ready signal, because the bus cannot be paused: clock stretching is not supported. Back-pressure therefore works through `busy`. If `busy` is high when a byte completes, the byte is not delivered and the master gets a NACK, which tells it to stop or retry. Transmit bytes are pulled from `tx_data`. The engine samples that input in the cycle where it pulses `tx_taken`, so the user must present the next byte before the master's next acknowledge clock ends. Status flags report whether the slave is selected, the transfer direction, and whether selection came through the general call.

Top module: `twb_slave`

## Requirements
- R1: A START is seen when SDA falls while SCL is high, and it begins address reception. A STOP is seen when SDA rises while SCL is high. A STOP releases SDA, clears all status flags and returns the engine to idle.
- R2: The address packet is shifted MSB first as seven address bits followed by a direction bit (1 = read, 0 = write). If the address equals `own_addr`, the slave asserts `sda_oe` through the ninth SCL clock.
- R3: After an address that does not select the slave, the slave leaves SDA released in the ninth clock. It keeps `sda_oe` low through any following bytes until the next START.
- R4: Addresses whose four upper bits are all ones are never acknowledged, even when `own_addr` holds such a value.
- R5: Address 0000000 with a write bit is acknowledged only when `gc_en` is high. In that case `st_gcall` goes high and the following data bytes are received.
- R6: Address 0000000 with a read bit is never acknowledged, and the slave drives no data after it.
- R7: When `busy` is high as the direction bit is sampled, the slave answers its own address with a NACK.
- R8: Write data is shifted MSB first. After the eighth bit, `rx_valid` pulses for exactly one cycle with the byte on `rx_data`, and the byte is acknowledged. If `busy` is high when the eighth bit is sampled, the byte is dropped without `rx_valid` and is NACKed.
- R9: In a read, `tx_data` is sampled when the acknowledge clock ends, and `tx_taken` pulses in that cycle. The byte is driven MSB first. `sda_oe` changes only while SCL is low.
- R10: An ACK from the master after a read byte loads the next byte. A NACK releases SDA, and the slave drives nothing more until the next START.
- R11: A repeated START in the middle of a packet aborts that packet, delivers no partial byte, and restarts address reception.
- R12: `st_active` rises when an address is acknowledged and stays high until a START or STOP. `st_read` holds the direction bit of the selected transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| own_addr | input | 7 | Programmable slave address |
| gc_en | input | 1 | Allow acknowledging the general call write |
| busy | input | 1 | User cannot accept; NACK address or byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | DATA_W | Received byte |
| tx_data | input | DATA_W | Next byte to transmit |
| tx_taken | output | 1 | Strobe: tx_data was loaded this cycle |
| st_active | output | 1 | Slave currently selected |
| st_read | output | 1 | Selected transfer is a read |
| st_gcall | output | 1 | Selected through the general call |

## Verification
A line change reaches the event decode two clocks later, through the synchronizer. The engine registers its response one clock after that. So `sda_oe`, `rx_valid` and `tx_taken` move on the third clock after the bus pin that caused them. The bench master holds each SCL phase for eight clocks and samples the data line six clocks into the high phase, by which time the slave's response has settled. A behavioural model with a queue of expected bytes is compared against `rx_valid` on every clock. On every clock where the model says the slave must stay silent, the bench also checks that `sda_oe` is low.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int ADDR_W = 7;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADEC, S_AACK,
    S_WDAT, S_WDEC, S_WACK,
    S_RDAT, S_RACK, S_SKIP
  } eng_state_t;

  // Decide whether an address packet is acknowledged.
  function automatic logic addr_accept(input logic [ADDR_W-1:0] a,
                                       input logic rw,
                                       input logic [ADDR_W-1:0] own,
                                       input logic gc_en,
                                       input logic busy);
    logic reserved, own_hit, gc_hit;
    reserved = (a[ADDR_W-1:ADDR_W-4] == 4'hF);
    own_hit  = (a == own) && (a != '0) && !reserved;
    gc_hit   = (a == '0) && !rw && gc_en;
    return !busy && (own_hit || gc_hit);
  endfunction
endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic prev
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '1;
        else        sr <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], din};
    end
  endgenerate

  assign level = sr[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= level;
endmodule

// File: rtl/twb_bus_events.sv
module twb_bus_events (
  input  logic scl_s,
  input  logic scl_p,
  input  logic sda_s,
  input  logic sda_p,
  output logic ev_start,
  output logic ev_stop,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_held;
  assign scl_held = scl_s && scl_p;
  assign ev_start = scl_held && sda_p && !sda_s;
  assign ev_stop  = scl_held && !sda_p && sda_s;
  assign scl_rise = scl_s && !scl_p;
  assign scl_fall = !scl_s && scl_p;
endmodule

// File: rtl/twb_engine.sv
module twb_engine
  import twb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              busy,
  input  logic [DATA_W-1:0] tx_data,
  output logic              sda_oe,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_taken,
  output logic              st_active,
  output logic              st_read,
  output logic              st_gcall
);
  localparam int ABYTE_W = ADDR_W + 1;
  localparam int MAX_W   = (DATA_W > ABYTE_W) ? DATA_W : ABYTE_W;
  localparam int CNT_W   = $clog2(MAX_W);
  localparam logic [CNT_W-1:0] ALAST = CNT_W'(ABYTE_W - 1);
  localparam logic [CNT_W-1:0] DLAST = CNT_W'(DATA_W - 1);

  eng_state_t         state;
  logic [CNT_W-1:0]   cnt;
  logic [ABYTE_W-1:0] asr;
  logic [DATA_W-1:0]  dsr;
  logic [DATA_W-1:0]  txsh;
  logic               ack_pend;
  logic               is_gc;
  logic               m_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      asr       <= '0;
      dsr       <= '0;
      txsh      <= '0;
      ack_pend  <= 1'b0;
      is_gc     <= 1'b0;
      m_ack     <= 1'b0;
      sda_oe    <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      tx_taken  <= 1'b0;
      st_active <= 1'b0;
      st_read   <= 1'b0;
      st_gcall  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_taken <= 1'b0;
      if (ev_start) begin
        state     <= S_ADDR;
        cnt       <= '0;
        sda_oe    <= 1'b0;
        st_active <= 1'b0;
        st_read   <= 1'b0;
        st_gcall  <= 1'b0;
      end else if (ev_stop) begin
        state     <= S_IDLE;
        sda_oe    <= 1'b0;
        st_active <= 1'b0;
        st_read   <= 1'b0;
        st_gcall  <= 1'b0;
      end else begin
        case (state)
          S_ADDR: if (scl_rise) begin
            asr <= {asr[ABYTE_W-2:0], sda_s};
            if (cnt == ALAST) begin
              ack_pend <= addr_accept(asr[ADDR_W-1:0], sda_s, own_addr, gc_en, busy);
              is_gc    <= (asr[ADDR_W-1:0] == '0);
              state    <= S_ADEC;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          S_ADEC: if (scl_fall) begin
            sda_oe <= ack_pend;
            if (ack_pend) begin
              st_active <= 1'b1;
              st_read   <= asr[0];
              st_gcall  <= is_gc;
            end
            state <= S_AACK;
          end
          S_AACK: if (scl_fall) begin
            cnt <= '0;
            if (!ack_pend) begin
              sda_oe <= 1'b0;
              state  <= S_SKIP;
            end else if (st_read) begin
              txsh     <= tx_data;
              sda_oe   <= !tx_data[DATA_W-1];
              tx_taken <= 1'b1;
              state    <= S_RDAT;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_WDAT;
            end
          end
          S_WDAT: if (scl_rise) begin
            dsr <= {dsr[DATA_W-2:0], sda_s};
            if (cnt == DLAST) begin
              ack_pend <= !busy;
              if (!busy) begin
                rx_valid <= 1'b1;
                rx_data  <= {dsr[DATA_W-2:0], sda_s};
              end
              state <= S_WDEC;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          S_WDEC: if (scl_fall) begin
            sda_oe <= ack_pend;
            state  <= S_WACK;
          end
          S_WACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= S_WDAT;
          end
          S_RDAT: if (scl_fall) begin
            if (cnt == DLAST) begin
              sda_oe <= 1'b0;
              state  <= S_RACK;
            end else begin
              txsh   <= {txsh[DATA_W-2:0], 1'b0};
              sda_oe <= !txsh[DATA_W-2];
              cnt    <= cnt + CNT_W'(1);
            end
          end
          S_RACK: begin
            if (scl_rise) m_ack <= !sda_s;
            if (scl_fall) begin
              cnt <= '0;
              if (m_ack) begin
                txsh     <= tx_data;
                sda_oe   <= !tx_data[DATA_W-1];
                tx_taken <= 1'b1;
                state    <= S_RDAT;
              end else begin
                state <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twb_slave.sv
module twb_slave
  import twb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              busy,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_taken,
  output logic              st_active,
  output logic              st_read,
  output logic              st_gcall
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, lvl, prv;
  logic scl_s, scl_p, sda_s, sda_p;
  logic ev_start, ev_stop, scl_rise, scl_fall;

  assign raw_lines = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_sync
      twb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_lines[g]),
        .level(lvl[g]),
        .prev (prv[g])
      );
    end
  endgenerate

  assign scl_s = lvl[0];
  assign scl_p = prv[0];
  assign sda_s = lvl[1];
  assign sda_p = prv[1];

  twb_bus_events u_events (
    .scl_s   (scl_s),
    .scl_p   (scl_p),
    .sda_s   (sda_s),
    .sda_p   (sda_p),
    .ev_start(ev_start),
    .ev_stop (ev_stop),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  twb_engine #(.DATA_W(DATA_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .own_addr (own_addr),
    .gc_en    (gc_en),
    .busy     (busy),
    .tx_data  (tx_data),
    .sda_oe   (sda_oe),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .tx_taken (tx_taken),
    .st_active(st_active),
    .st_read  (st_read),
    .st_gcall (st_gcall)
  );
endmodule

// File: rtl/twb_slave_chk.sv
module twb_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       ev_stop,
  input logic       sda_oe,
  input logic       rx_valid,
  input logic       tx_taken,
  input logic       st_active,
  input logic       st_read,
  input logic       st_gcall,
  input logic [6:0] own_addr
);
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R9
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!st_active && !sda_oe)); // R1
  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R8
  AST_RX_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (st_active && !st_read)); // R12
  AST_TX_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |-> (st_active && st_read)); // R9
  AST_GCALL_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    st_gcall |-> (st_active && !st_read)); // R6
  AST_NO_RESERVED_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_active) && !st_gcall) |-> (own_addr[6:3] != 4'hF)); // R4
endmodule

bind twb_slave twb_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .ev_stop  (ev_stop),
  .sda_oe   (sda_oe),
  .rx_valid (rx_valid),
  .tx_taken (tx_taken),
  .st_active(st_active),
  .st_read  (st_read),
  .st_gcall (st_gcall),
  .own_addr (own_addr)
);

// File: tb/twb_slave_bench.sv
`timescale 1ns/1ps
module twb_slave_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_oe;
  logic [6:0] own_addr = 7'h2C;
  logic       gc_en = 1'b0;
  logic       busy = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic [7:0] tx_data = 8'hA5;
  logic       tx_taken;
  logic       st_active, st_read, st_gcall;

  int n_cmp = 0;
  int n_bad = 0;
  int n_tx  = 0;
  bit quiet = 1'b0;
  bit done  = 1'b0;
  logic [7:0] rxq[$];

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  twb_slave u_twb_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .own_addr(own_addr), .gc_en(gc_en), .busy(busy),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_data(tx_data), .tx_taken(tx_taken),
    .st_active(st_active), .st_read(st_read), .st_gcall(st_gcall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Per-clock model comparison: receive stream, silence, transmit loads.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        if (rxq.size() == 0) chk("R8 unexpected rx_valid", 1, 0);
        else chk("R8 rx_data", {24'd0, rx_data}, {24'd0, rxq.pop_front()});
      end
      if (quiet) chk("R3 slave silent", {31'd0, sda_oe}, 0);
      if (tx_taken) begin
        n_tx++;
        tx_data <= tx_data + 8'h11;
      end
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    wait_n(4); sda_m = b;
    wait_n(4); scl_m = 1'b1;
    wait_n(6); seen = sda_bus;
    wait_n(2); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    wait_n(4); sda_m = 1'b1;
    wait_n(4); scl_m = 1'b1;
    wait_n(4); sda_m = 1'b0;
    wait_n(4); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_n(4); sda_m = 1'b0;
    wait_n(4); scl_m = 1'b1;
    wait_n(4); sda_m = 1'b1;
    wait_n(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      d[i] = s;
    end
    bus_bit(!mack, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    report();
  end

  initial begin
    logic ak;
    logic s;
    logic [7:0] d;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    chk("R1 reset sda_oe", {31'd0, sda_oe}, 0);
    chk("R12 reset st_active", {31'd0, st_active}, 0);
    chk("R8 reset rx_valid", {31'd0, rx_valid}, 0);

    // Write to own address, three bytes.
    bus_start();
    send_byte({7'h2C, 1'b0}, ak); chk("R2 own write ack", {31'd0, ak}, 1);
    chk("R12 st_active", {31'd0, st_active}, 1);
    chk("R12 st_read write", {31'd0, st_read}, 0);
    rxq.push_back(8'h81); send_byte(8'h81, ak); chk("R8 ack 81", {31'd0, ak}, 1);
    rxq.push_back(8'h5A); send_byte(8'h5A, ak); chk("R8 ack 5A", {31'd0, ak}, 1);
    rxq.push_back(8'hFF); send_byte(8'hFF, ak); chk("R8 ack FF", {31'd0, ak}, 1);
    bus_stop();
    chk("R1 stop clears st_active", {31'd0, st_active}, 0);

    // Other address: NACK and silence.
    quiet = 1'b1;
    bus_start();
    send_byte({7'h2D, 1'b0}, ak); chk("R3 other addr nack", {31'd0, ak}, 0);
    send_byte(8'h33, ak); chk("R3 data after nack", {31'd0, ak}, 0);
    bus_stop();

    // Reserved own address never acknowledged.
    own_addr = 7'h7A;
    bus_start();
    send_byte({7'h7A, 1'b0}, ak); chk("R4 reserved nack", {31'd0, ak}, 0);
    bus_stop();
    own_addr = 7'h2C;

    // General call disabled.
    bus_start();
    send_byte(8'h00, ak); chk("R5 gcall disabled nack", {31'd0, ak}, 0);
    bus_stop();
    quiet = 1'b0;

    // General call enabled, write.
    gc_en = 1'b1;
    bus_start();
    send_byte(8'h00, ak); chk("R5 gcall ack", {31'd0, ak}, 1);
    chk("R5 st_gcall", {31'd0, st_gcall}, 1);
    rxq.push_back(8'h42); send_byte(8'h42, ak); chk("R5 gcall data ack", {31'd0, ak}, 1);
    bus_stop();

    // General call with read bit.
    quiet = 1'b1;
    bus_start();
    send_byte(8'h01, ak); chk("R6 gcall read nack", {31'd0, ak}, 0);
    read_byte(1'b0, d); chk("R6 no data driven", {24'd0, d}, 32'hFF);
    bus_stop();

    // Busy at address.
    busy = 1'b1;
    bus_start();
    send_byte({7'h2C, 1'b0}, ak); chk("R7 busy address nack", {31'd0, ak}, 0);
    bus_stop();
    busy = 1'b0;
    quiet = 1'b0;

    // Busy during a data byte.
    bus_start();
    send_byte({7'h2C, 1'b0}, ak); chk("R2 ack before busy data", {31'd0, ak}, 1);
    rxq.push_back(8'h11); send_byte(8'h11, ak); chk("R8 ack 11", {31'd0, ak}, 1);
    busy = 1'b1;
    send_byte(8'h22, ak); chk("R8 busy byte nack", {31'd0, ak}, 0);
    busy = 1'b0;
    rxq.push_back(8'h33); send_byte(8'h33, ak); chk("R8 ack after busy", {31'd0, ak}, 1);
    bus_stop();

    // Read of three bytes.
    n_tx = 0;
    bus_start();
    send_byte({7'h2C, 1'b1}, ak); chk("R2 own read ack", {31'd0, ak}, 1);
    chk("R12 st_read", {31'd0, st_read}, 1);
    read_byte(1'b1, d); chk("R9 read byte 0", {24'd0, d}, 32'hA5);
    read_byte(1'b1, d); chk("R10 read byte 1", {24'd0, d}, 32'hB6);
    read_byte(1'b0, d); chk("R10 read byte 2", {24'd0, d}, 32'hC7);
    quiet = 1'b1;
    wait_n(20);
    chk("R10 load count", n_tx, 3);
    bus_stop();
    quiet = 1'b0;

    // Repeated START in the middle of a byte.
    bus_start();
    send_byte({7'h2C, 1'b0}, ak); chk("R11 first ack", {31'd0, ak}, 1);
    for (int i = 0; i < 4; i++) bus_bit(1'b1, s);
    bus_start();
    send_byte({7'h2C, 1'b0}, ak); chk("R11 restart ack", {31'd0, ak}, 1);
    rxq.push_back(8'h99); send_byte(8'h99, ak); chk("R11 data after restart", {31'd0, ak}, 1);
    bus_stop();

    wait_n(10);
    chk("R8 queue drained", rxq.size(), 0);
    report();
  end
endmodule